// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

The controller turns single requests from an internal interface into one access on a 16-bit asynchronous SRAM-style external bus. A request carries the direction, a 25-bit address, an active-high byte-lane enable, write data, a 3-bit chip-select index and two timing fields. Every external strobe is placed in whole bus-clock cycles. The timing fields are `m` (0 to 15 cycles) and `n`. `m` sets the hold after the strobe and, on reads, the delay from chip select to the strobe. `n` sets the strobe width and, on writes, the delay from chip select to the strobe.

The controller takes a request only while it is idle, which is shown by `req_ready_o`. The transfer then runs through setup, strobe and hold. At the end the controller gives a one-cycle `rsp_done_o` pulse. Read data is captured on the clock edge that ends the output-enable strobe, and it stays on `rsp_rdata_o` until the next read captures new data.

Top module: `asram_bus_ctrl`

## Requirements
- R1: While idle, and immediately on asynchronous reset, all chip selects, output enable and write enable are high. The byte-lane outputs are `2'b11`, the data driver enable is 0, `rsp_done_o` is 0 and `req_ready_o` is 1.
- R2: An accepted request drives exactly one chip select low, bit `req_cs_i`, from the first cycle after acceptance. The address is driven in that same first cycle. Chip select and address do not change while chip select is low.
- R3: On a read, output enable falls `m` cycles after chip select falls. With `m` = 0 it falls in the same cycle. The byte-lane outputs carry the inverted lane enables from that cycle on.
- R4: On a read, output enable stays low for exactly `n` cycles. `req_n_i` encodes `n` - 1, so a code of 0..15 gives 1..16 cycles.
- R5: On either direction, chip select and address remain valid for `m` cycles after the strobe rises. With `m` = 0, chip select rises in the same cycle as the strobe.
- R6: Read data is sampled from `bus_dq_i` at the clock edge where output enable rises. It is presented on `rsp_rdata_o` from the next cycle and is unchanged by writes and by idle cycles.
- R7: On a write, write enable and the byte-lane outputs assert `n` cycles after chip select falls. Write enable stays low for `n` cycles.
- R8: On a write, the data bus is driven with the request's write data, with `bus_dq_oe_o` = 1. This starts in the cycle write enable falls and lasts until chip select rises, which covers the `m` hold cycles.
- R9: `rsp_done_o` is high for exactly one cycle: the first cycle with all chip selects high after the hold. `req_ready_o` is low from acceptance through the done cycle, and requests presented while it is low have no effect.
- R10: A read never pulls write enable low and never enables the data driver. A write never pulls output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 25 | Word address |
| req_be_i | input | 2 | Byte-lane enables, active high |
| req_wdata_i | input | 16 | Write data |
| req_cs_i | input | 3 | Chip-select index |
| req_m_i | input | 4 | Setup/hold cycles `m` |
| req_n_i | input | 4 | Strobe width code, `n` - 1 |
| rsp_rdata_o | output | 16 | Captured read data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| bus_cs_no | output | 8 | Chip selects, active low |
| bus_oe_no | output | 1 | Output enable, active low |
| bus_we_no | output | 1 | Write enable, active low |
| bus_be_no | output | 2 | Byte-lane strobes, active low |
| bus_addr_o | output | 25 | External address |
| bus_dq_o | output | 16 | Write data to the pad driver |
| bus_dq_oe_o | output | 1 | Data pad driver enable |
| bus_dq_i | input | 16 | Read data from the pads |

## Verification
The properties assume that the request fields are sampled only at acceptance, so changes to them while `req_ready_o` is low must have no visible effect. They also assume that `bus_dq_i` matters only at the edge that ends a read strobe. The stimulus changes `bus_dq_i` on every cycle of a read, which pins the capture to exactly one edge. It also raises a conflicting request in the middle of a transfer. Timing fields cover both ends of each range, including `m` = 0 and `n` = 16, for reads and writes. Reset is asserted once in the middle of a write to check the asynchronous return to the idle pin state.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phase_e;

  localparam int unsigned TIM_W = 4;
endpackage

// File: rtl/asram_cs_dec.sv
module asram_cs_dec #(
  parameter int unsigned CS_N  = 8,
  parameter int unsigned IDX_W = $clog2(CS_N)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_i,
  output logic [CS_N-1:0]  cs_no
);
  for (genvar g = 0; g < CS_N; g++) begin : g_cs
    assign cs_no[g] = ~(en_i && (idx_i == IDX_W'(g)));
  end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CNT_W = TIM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [CNT_W-1:0] m_i,
  input  logic [CNT_W-1:0] ncode_i,
  output phase_e           phase_o,
  output logic             last_strobe_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] m_q;
  logic [CNT_W-1:0] n_q;
  logic             cnt_zero;

  assign cnt_zero      = (cnt_q == '0);
  assign phase_o       = phase_q;
  assign last_strobe_o = (phase_q == PH_STROBE) && cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      m_q     <= '0;
      n_q     <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          m_q <= m_i;
          n_q <= ncode_i;
          if (write_i) begin
            // write strobe delay uses the width field
            phase_q <= PH_SETUP;
            cnt_q   <= ncode_i;
          end else if (m_i == '0) begin
            phase_q <= PH_STROBE;
            cnt_q   <= ncode_i;
          end else begin
            phase_q <= PH_SETUP;
            cnt_q   <= m_i - CNT_W'(1);
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase_q <= PH_STROBE;
            cnt_q   <= n_q;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt_zero) begin
            if (m_q == '0) begin
              phase_q <= PH_DONE;
            end else begin
              phase_q <= PH_HOLD;
              cnt_q   <= m_q - CNT_W'(1);
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_zero) phase_q <= PH_DONE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 25,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CS_N   = 8,
  parameter int unsigned IDX_W  = $clog2(CS_N),
  parameter int unsigned LANE_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  cs_i,
  input  phase_e            phase_i,
  input  logic              last_strobe_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CS_N-1:0]   cs_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [LANE_W-1:0] be_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANE_W-1:0] be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  cs_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cs_act, strobe, post;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      cs_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (load_i) begin
        wr_q    <= write_i;
        addr_q  <= addr_i;
        be_q    <= be_i;
        wdata_q <= wdata_i;
        cs_q    <= cs_i;
      end
      if (last_strobe_i && !wr_q) rdata_q <= dq_i;
    end
  end

  assign strobe = (phase_i == PH_STROBE);
  assign post   = (phase_i == PH_HOLD);
  assign cs_act = (phase_i == PH_SETUP) || strobe || post;

  asram_cs_dec #(.CS_N(CS_N), .IDX_W(IDX_W)) u_cs_dec (
    .idx_i (cs_q),
    .en_i  (cs_act),
    .cs_no (cs_no)
  );

  assign oe_no   = ~(strobe && !wr_q);
  assign we_no   = ~(strobe && wr_q);
  assign be_no   = (strobe || post) ? ~be_q : '1;
  assign dq_oe_o = wr_q && (strobe || post);
  assign dq_o    = dq_oe_o ? wdata_q : '0;
  assign addr_o  = addr_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/asram_bus_ctrl.sv
module asram_bus_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 25,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CS_N   = 8,
  parameter int unsigned CNT_W  = TIM_W,
  localparam int unsigned IDX_W  = $clog2(CS_N),
  localparam int unsigned LANE_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LANE_W-1:0] req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [IDX_W-1:0]  req_cs_i,
  input  logic [CNT_W-1:0]  req_m_i,
  input  logic [CNT_W-1:0]  req_n_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_done_o,
  output logic [CS_N-1:0]   bus_cs_no,
  output logic              bus_oe_no,
  output logic              bus_we_no,
  output logic [LANE_W-1:0] bus_be_no,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe_o,
  input  logic [DATA_W-1:0] bus_dq_i
);
  phase_e phase;
  logic   last_strobe;
  logic   start;

  assign req_ready_o = (phase == PH_IDLE);
  assign start       = req_valid_i && req_ready_o;
  assign rsp_done_o  = (phase == PH_DONE);

  asram_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .write_i       (req_write_i),
    .m_i           (req_m_i),
    .ncode_i       (req_n_i),
    .phase_o       (phase),
    .last_strobe_o (last_strobe)
  );

  asram_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CS_N   (CS_N),
    .IDX_W  (IDX_W),
    .LANE_W (LANE_W)
  ) u_pins (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (start),
    .write_i       (req_write_i),
    .addr_i        (req_addr_i),
    .be_i          (req_be_i),
    .wdata_i       (req_wdata_i),
    .cs_i          (req_cs_i),
    .phase_i       (phase),
    .last_strobe_i (last_strobe),
    .dq_i          (bus_dq_i),
    .rdata_o       (rsp_rdata_o),
    .cs_no         (bus_cs_no),
    .oe_no         (bus_oe_no),
    .we_no         (bus_we_no),
    .be_no         (bus_be_no),
    .addr_o        (bus_addr_o),
    .dq_o          (bus_dq_o),
    .dq_oe_o       (bus_dq_oe_o)
  );
endmodule

// File: rtl/asram_bus_chk.sv
module asram_bus_chk #(
  parameter int unsigned ADDR_W = 25,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CS_N   = 8,
  parameter int unsigned LANE_W = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_done_o,
  input logic [CS_N-1:0]   bus_cs_no,
  input logic              bus_oe_no,
  input logic              bus_we_no,
  input logic [LANE_W-1:0] bus_be_no,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_dq_oe_o
);
  logic cs_any;
  assign cs_any = ~&bus_cs_no;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (&bus_cs_no && bus_oe_no && bus_we_no && &bus_be_no && !bus_dq_oe_o)); // R1
  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~bus_cs_no) <= 1); // R2
  AST_CS_ADDR_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_any && $past(cs_any)) |-> ($stable(bus_cs_no) && $stable(bus_addr_o))); // R2
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_oe_no || !bus_we_no) |-> cs_any); // R3
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_no && $past(bus_oe_no)) |-> $stable(rsp_rdata_o)); // R6
  AST_WE_DRIVES_DQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_no |-> bus_dq_oe_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o); // R9
  AST_DONE_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> (&bus_cs_no && !req_ready_o && $past(cs_any))); // R9
  AST_NO_OE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_oe_no && !bus_we_no)); // R10
  AST_OE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_no |-> !bus_dq_oe_o); // R10
endmodule

bind asram_bus_ctrl asram_bus_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CS_N   (CS_N),
  .LANE_W (LANE_W)
) u_chk (.*);

// File: tb/sim_asram_bus_ctrl.sv
`timescale 1ns/1ps
module sim_asram_bus_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [24:0] req_addr_i = '0;
  logic [1:0]  req_be_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [2:0]  req_cs_i = '0;
  logic [3:0]  req_m_i = '0;
  logic [3:0]  req_n_i = '0;
  logic [15:0] rsp_rdata_o;
  logic        rsp_done_o;
  logic [7:0]  bus_cs_no;
  logic        bus_oe_no, bus_we_no;
  logic [1:0]  bus_be_no;
  logic [24:0] bus_addr_o;
  logic [15:0] bus_dq_o;
  logic        bus_dq_oe_o;
  logic [15:0] bus_dq_i = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] last_rd = '0;

  always #10 clk_i = ~clk_i;

  asram_bus_ctrl u0 (.*);

  // {wr, m, n-1, cs, be, cycles with cs low}
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 4'd0,  4'd0,  3'd0, 2'b11, 8'd1},
    {1'b0, 4'd3,  4'd3,  3'd5, 2'b01, 8'd10},
    {1'b1, 4'd0,  4'd0,  3'd7, 2'b11, 8'd2},
    {1'b1, 4'd2,  4'd2,  3'd2, 2'b10, 8'd8},
    {1'b0, 4'd15, 4'd15, 3'd3, 2'b11, 8'd46},
    {1'b1, 4'd15, 4'd15, 3'd1, 2'b11, 8'd47},
    {1'b0, 4'd1,  4'd1,  3'd6, 2'b10, 8'd4},
    {1'b1, 4'd4,  4'd0,  3'd4, 2'b01, 8'd6}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(bus_cs_no == 8'hFF, req, "cs idle", bus_cs_no, 8'hFF);
    chk({bus_oe_no, bus_we_no, bus_be_no, bus_dq_oe_o} == 5'b11110, req,
        "strobes idle", {bus_oe_no, bus_we_no, bus_be_no, bus_dq_oe_o}, 5'b11110);
    chk(req_ready_o && !rsp_done_o, req, "ready/done idle",
        {req_ready_o, rsp_done_o}, 2'b10);
  endtask

  task automatic run_txn(input int i);
    logic [21:0] v = VEC[i];
    bit          wr = v[21];
    int          m = int'(v[20:17]);
    int          n = int'(v[16:13]) + 1;
    logic [2:0]  cs = v[12:10];
    logic [1:0]  be = v[9:8];
    int          len = int'(v[7:0]);
    logic [24:0] addr = 25'h0A5000 + 25'(i * 'h1111);
    logic [15:0] wd = 16'hC300 + 16'(i);
    logic [15:0] base = 16'h4000 + 16'(i * 'h100);
    int first = -1, scnt = 0, cscnt = 0, csfirst = -1, done_k = -1, done_n = 0;
    bit cs_ok = 1, be_ok = 1, dq_ok = 1, other_ok = 1, rdy_ok = 1;
    @(negedge clk_i);
    chk(req_ready_o, "R9", "ready before request", req_ready_o, 1);
    req_valid_i = 1; req_write_i = wr; req_addr_i = addr; req_be_i = be;
    req_wdata_i = wd; req_cs_i = cs; req_m_i = 4'(m); req_n_i = 4'(n - 1);
    for (int k = 0; k <= len + 1; k++) begin
      @(negedge clk_i);
      req_valid_i = 0;
      bus_dq_i = base + 16'(k);
      if (bus_cs_no != 8'hFF) begin
        if (csfirst < 0) csfirst = k;
        cscnt++;
        if (bus_cs_no != ~(8'b1 << cs) || bus_addr_o != addr) cs_ok = 0;
        if (wr && first >= 0 && !(bus_dq_oe_o && bus_dq_o == wd)) dq_ok = 0;
      end
      if (wr ? !bus_we_no : !bus_oe_no) begin
        if (first < 0) first = k;
        scnt++;
        if (bus_be_no != ~be) be_ok = 0;
        if (wr && !(bus_dq_oe_o && bus_dq_o == wd)) dq_ok = 0;
      end
      if (wr ? !bus_oe_no : (!bus_we_no || bus_dq_oe_o)) other_ok = 0;
      if (rsp_done_o) begin done_n++; done_k = k; end
      if (k <= len && req_ready_o) rdy_ok = 0;
    end
    chk(csfirst == 0 && cscnt == len && cs_ok, "R2", "cs/addr window",
        cscnt, len);
    if (!wr) begin
      chk(first == m, "R3", "oe fall offset", first, m);
      chk(scnt == n, "R4", "oe width", scnt, n);
      chk(rsp_rdata_o == base + 16'(m + n - 1), "R6", "read capture",
          rsp_rdata_o, base + 16'(m + n - 1));
      last_rd = base + 16'(m + n - 1);
    end else begin
      chk(first == n && scnt == n, "R7", "we offset/width", {first, scnt}, {n, n});
      chk(dq_ok, "R8", "write data drive", dq_ok, 1);
      chk(rsp_rdata_o == last_rd, "R6", "rdata held over write", rsp_rdata_o, last_rd);
    end
    chk(be_ok, wr ? "R7" : "R3", "byte lanes", be_ok, 1);
    chk(cscnt - (first + n) == m, "R5", "hold after strobe", cscnt - (first + n), m);
    chk(done_n == 1 && done_k == len && rdy_ok, "R9", "done pulse", done_k, len);
    chk(other_ok, "R10", "wrong strobe", other_ok, 1);
    chk_idle("R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5;
    chk_idle("R1");
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk_idle("R1");

    for (int i = 0; i < 8; i++) run_txn(i);

    // R9: conflicting request raised while busy must be ignored
    begin
      bit ok = 1;
      int cnt = 0;
      @(negedge clk_i);
      req_valid_i = 1; req_write_i = 0; req_addr_i = 25'h1234; req_be_i = 2'b11;
      req_cs_i = 3'd1; req_m_i = 4'd2; req_n_i = 4'd1;
      for (int k = 0; k <= 6; k++) begin
        @(negedge clk_i);
        bus_dq_i = 16'h7700 + 16'(k);
        if (k == 1) begin
          req_write_i = 1; req_cs_i = 3'd6; req_addr_i = 25'h1FFFF; req_m_i = 4'd0;
        end
        if (k == 6) req_valid_i = 0;
        if (bus_cs_no != 8'hFF) begin
          cnt++;
          if (bus_cs_no != 8'hFD || bus_addr_o != 25'h1234 || !bus_we_no) ok = 0;
        end
      end
      chk(ok && cnt == 6, "R9", "busy request ignored", cnt, 6);
      chk(rsp_rdata_o == 16'h7703, "R6", "capture at oe rise", rsp_rdata_o, 16'h7703);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i);
        chk(bus_cs_no == 8'hFF, "R9", "no late start", bus_cs_no, 8'hFF);
      end
    end

    // R1: asynchronous reset in the middle of a write
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_cs_i = 3'd2; req_m_i = 4'd5; req_n_i = 4'd15;
    @(negedge clk_i);
    req_valid_i = 0;
    repeat (20) @(negedge clk_i);
    chk(!bus_we_no && bus_dq_oe_o, "R7", "mid-write strobe", bus_we_no, 0);
    rst_ni = 0;
    #1;
    chk_idle("R1");
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk_idle("R1");
    chk(rsp_rdata_o == 16'h0, "R1", "rdata after reset", rsp_rdata_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule